// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which hardware thread of a multithreaded out-of-order core gets the next commit slot. For every thread it receives a 3-bit thread state, a flag saying the oldest reorder-buffer entry of that thread is ready to retire, a flag saying that thread's reorder buffer is empty, and the sequence number of that oldest entry. From these and a 2-bit policy selector it produces a combinational grant: a valid bit and a thread index.

Three arbitration policies exist. The age policy grants the qualifying thread whose oldest entry carries the smallest sequence number. The greedy policy makes the same choice and keeps no state, so the commit loop may ask it several times within one cycle. The rotating policy walks an ordered priority list, the only state in the block. Its front-to-back walk grants the first qualifying thread, and when the commit loop pulses `advance` the granted thread is moved to the back of the list. When the block is built for a single thread, the policy logic is left out and the thread is granted whenever its state permits.

The block has two states. In the rotation list, IDLE_HOLD keeps the list as it is, and ROTATE takes the granted thread out and puts it at the back. The HOLD transition is taken whenever `advance` is low, no thread is granted or the policy is not rotating. The ROTATE transition is taken on a rising clock edge where `advance` is high and the rotating policy makes a grant.

Top module: `commit_thread_sel`

## Requirements
- R1: Thread state encoding is 0 running, 1 idle, 2 squashing, 3 trap wait, 4 fetch-trap wait, 5 to 7 unused. Only states 0, 1 and 4 make a thread eligible.
- R2: Policy encoding is 0 greedy, 1 rotating, 2 age and 3 reserved. The reserved value never produces a grant.
- R3: Under the age policy a thread qualifies when it is eligible, its ready flag is 1 and its empty flag is 0. The qualifying thread with the smallest unsigned head sequence number is granted.
- R4: Under the greedy and age policies, equal head sequence numbers are resolved in favour of the lower thread index.
- R5: The greedy policy grants the same thread as the age policy for the same inputs. `advance` has no effect on its grant, either in the same cycle or in later cycles.
- R6: Under the rotating policy a thread qualifies when it is eligible and its ready flag is 1, whatever its empty flag. The first qualifying thread from the front of the list is granted.
- R7: A rising edge with `advance` high and a rotating grant moves the granted thread to the back of the list, and the other threads keep their relative order. Without such an edge the list does not change, and `advance` under other policies leaves it untouched.
- R8: After reset the list holds threads 0, 1, 2 and so on, front to back.
- R9: When no thread qualifies, `sel_valid` is 0 and `sel_tid` is 0.
- R10: With NUM_THREADS = 1, `sel_valid` equals the eligibility of thread 0's state and `sel_tid` is 0. Policy, ready and empty flags are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy | input | 2 | Arbitration policy code |
| thr_state | input | 3*NUM_THREADS | Per-thread state, thread i at bits [3i+2:3i] |
| head_ready | input | NUM_THREADS | Oldest entry of thread i ready to retire |
| rob_empty | input | NUM_THREADS | Reorder buffer of thread i empty |
| head_seq | input | SEQ_W*NUM_THREADS | Sequence number of thread i's oldest entry |
| advance | input | 1 | Commit loop consumed the current grant |
| sel_valid | output | 1 | A thread is granted |
| sel_tid | output | TID_W | Granted thread index |

## Verification
The only internal state is the rotation list. A corrupt list shows up on the first grant after the faulty edge: the bench sees a thread granted out of order or the same thread granted twice in a row. It compares each rotating grant against a list kept in the bench. Errors in the age comparator are visible at once, in the same cycle, so each pattern of sequence numbers, ties and disqualifying flags is checked directly at `sel_tid`.

// File: rtl/ctsel_pkg.sv
package ctsel_pkg;

    localparam int ST_W = 3;

    typedef enum logic [2:0] {
        TS_RUNNING         = 3'd0,
        TS_IDLE            = 3'd1,
        TS_SQUASHING       = 3'd2,
        TS_TRAP_WAIT       = 3'd3,
        TS_FETCH_TRAP_WAIT = 3'd4
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_GREEDY = 2'd0,
        POL_ROTATE = 2'd1,
        POL_AGE    = 2'd2,
        POL_RSVD   = 2'd3
    } pol_e;

    typedef enum logic {
        RL_IDLE_HOLD = 1'b0,
        RL_ROTATE    = 1'b1
    } rl_step_e;

    function automatic logic st_eligible(input logic [ST_W-1:0] s);
        return (s == TS_RUNNING) || (s == TS_IDLE) || (s == TS_FETCH_TRAP_WAIT);
    endfunction

endpackage

// File: rtl/ctsel_qualify.sv
module ctsel_qualify
    import ctsel_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [ST_W*NUM_THREADS-1:0] thr_state,
    input  logic [NUM_THREADS-1:0]      head_ready,
    input  logic [NUM_THREADS-1:0]      rob_empty,
    output logic [NUM_THREADS-1:0]      rot_ok,
    output logic [NUM_THREADS-1:0]      age_ok
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic elig;
        assign elig      = st_eligible(thr_state[t*ST_W +: ST_W]);
        assign rot_ok[t] = elig && head_ready[t];
        assign age_ok[t] = elig && head_ready[t] && !rob_empty[t];
    end
endmodule

// File: rtl/ctsel_age.sv
module ctsel_age #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]       age_ok,
    input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
    output logic                         found,
    output logic [TID_W-1:0]             tid
);
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        found    = 1'b0;
        tid      = '0;
        best_seq = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (age_ok[t] && (!found || head_seq[t*SEQ_W +: SEQ_W] < best_seq)) begin
                found    = 1'b1;
                tid      = TID_W'(t);
                best_seq = head_seq[t*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/ctsel_rotate.sv
module ctsel_rotate
    import ctsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] rot_ok,
    input  logic                   take,
    output logic                   found,
    output logic [TID_W-1:0]       tid
);
    logic [TID_W-1:0] order_q [NUM_THREADS];
    logic [TID_W-1:0] order_n [NUM_THREADS];
    logic [TID_W-1:0] pos;
    rl_step_e         step;

    // Walk from the front of the list.
    always_comb begin
        found = 1'b0;
        tid   = '0;
        pos   = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            if (!found && rot_ok[order_q[p]]) begin
                found = 1'b1;
                tid   = order_q[p];
                pos   = TID_W'(p);
            end
        end
    end

    assign step = (take && found) ? RL_ROTATE : RL_IDLE_HOLD;

    always_comb begin
        for (int p = 0; p < NUM_THREADS; p++) begin
            order_n[p] = order_q[p];
        end
        unique case (step)
            RL_IDLE_HOLD: ;
            RL_ROTATE: begin
                for (int p = 0; p < NUM_THREADS; p++) begin
                    if (p >= int'(pos)) begin
                        order_n[p] = (p == NUM_THREADS - 1) ? tid
                                   : order_q[(p + 1) % NUM_THREADS];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_THREADS; p++) begin
                order_q[p] <= TID_W'(p);
            end
        end else begin
            for (int p = 0; p < NUM_THREADS; p++) begin
                order_q[p] <= order_n[p];
            end
        end
    end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
    import ctsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   policy,
    input  logic [ST_W*NUM_THREADS-1:0]  thr_state,
    input  logic [NUM_THREADS-1:0]       head_ready,
    input  logic [NUM_THREADS-1:0]       rob_empty,
    input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
    input  logic                         advance,
    output logic                         sel_valid,
    output logic [TID_W-1:0]             sel_tid
);
    if (NUM_THREADS == 1) begin : g_single
        assign sel_valid = st_eligible(thr_state[ST_W-1:0]);
        assign sel_tid   = '0;
    end else begin : g_multi
        logic [NUM_THREADS-1:0] rot_ok, age_ok;
        logic                   age_found, rot_found;
        logic [TID_W-1:0]       age_tid, rot_tid;
        pol_e                   pol;

        assign pol = pol_e'(policy);

        ctsel_qualify #(.NUM_THREADS(NUM_THREADS)) u_qual (
            .thr_state (thr_state),
            .head_ready(head_ready),
            .rob_empty (rob_empty),
            .rot_ok    (rot_ok),
            .age_ok    (age_ok)
        );

        ctsel_age #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
            .age_ok  (age_ok),
            .head_seq(head_seq),
            .found   (age_found),
            .tid     (age_tid)
        );

        ctsel_rotate #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rot (
            .clk   (clk),
            .rst_n (rst_n),
            .rot_ok(rot_ok),
            .take  (advance && (pol == POL_ROTATE)),
            .found (rot_found),
            .tid   (rot_tid)
        );

        always_comb begin
            sel_valid = 1'b0;
            sel_tid   = '0;
            unique case (pol)
                POL_GREEDY, POL_AGE: begin
                    sel_valid = age_found;
                    sel_tid   = age_found ? age_tid : '0;
                end
                POL_ROTATE: begin
                    sel_valid = rot_found;
                    sel_tid   = rot_found ? rot_tid : '0;
                end
                POL_RSVD: ;
            endcase
        end
    end
endmodule

// File: rtl/ctsel_checker.sv
module ctsel_checker #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   policy,
    input logic [3*NUM_THREADS-1:0]     thr_state,
    input logic [NUM_THREADS-1:0]       head_ready,
    input logic [NUM_THREADS-1:0]       rob_empty,
    input logic [SEQ_W*NUM_THREADS-1:0] head_seq,
    input logic                         advance,
    input logic                         sel_valid,
    input logic [TID_W-1:0]             sel_tid
);
    logic [NUM_THREADS-1:0] can_rot, can_age;
    logic                   any_q, better_exists, sel_ok;

    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            logic [2:0] s;
            s = thr_state[i*3 +: 3];
            can_rot[i] = (s == 3'd0 || s == 3'd1 || s == 3'd4) && head_ready[i];
            can_age[i] = can_rot[i] && !rob_empty[i];
        end
        any_q = (policy == 2'd1) ? (can_rot != '0)
              : (policy == 2'd3) ? 1'b0 : (can_age != '0);
        better_exists = 1'b0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (can_age[i] && ((head_seq[i*SEQ_W +: SEQ_W] < head_seq[int'(sel_tid)*SEQ_W +: SEQ_W]) ||
                (head_seq[i*SEQ_W +: SEQ_W] == head_seq[int'(sel_tid)*SEQ_W +: SEQ_W] && i < int'(sel_tid))))
                better_exists = 1'b1;
        end
        sel_ok = (policy == 2'd1) ? can_rot[sel_tid] : can_age[sel_tid];
    end

    if (NUM_THREADS > 1) begin : g_multi_chk
        AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid |-> sel_ok);                                                   // R6
        AST_NO_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
            !any_q |-> (!sel_valid && sel_tid == '0));                               // R9
        AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_valid && policy != 2'd1) |-> !better_exists);                       // R3
        AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (policy == 2'd3) |-> !sel_valid);                                        // R2
        AST_ROTATE_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (policy == 2'd1 && advance && sel_valid && $countones(can_rot) > 1) |=>
            (($stable(policy) && $stable(thr_state) && $stable(head_ready)) -> sel_tid != $past(sel_tid))); // R7
    end else begin : g_single_chk
        AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid == (thr_state[2:0] == 3'd0 || thr_state[2:0] == 3'd1 || thr_state[2:0] == 3'd4)); // R10
    end
endmodule

bind commit_thread_sel ctsel_checker #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .policy    (policy),
    .thr_state (thr_state),
    .head_ready(head_ready),
    .rob_empty (rob_empty),
    .head_seq  (head_seq),
    .advance   (advance),
    .sel_valid (sel_valid),
    .sel_tid   (sel_tid)
);

// File: tb/sim_commit_thread_sel.sv
module sim_commit_thread_sel;
    localparam int N  = 4;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy = 2'd0;
    logic [2:0] st [N];
    logic [N-1:0] rdy = '0, emp = '0;
    logic [SW-1:0] sq [N];
    logic advance = 1'b0;
    logic [3*N-1:0] st_flat;
    logic [SW*N-1:0] sq_flat;
    logic sel_valid;
    logic [1:0] sel_tid;

    logic [2:0] st1 = 3'd0;
    logic [1:0] pol1 = 2'd3;
    logic rdy1 = 1'b0, emp1 = 1'b1;
    logic s1_valid;
    logic s1_tid;

    int tests_run = 0, failed = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_flat[i*3 +: 3]   = st[i];
            sq_flat[i*SW +: SW] = sq[i];
        end
    end

    commit_thread_sel #(.NUM_THREADS(N), .SEQ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .policy(policy), .thr_state(st_flat),
        .head_ready(rdy), .rob_empty(emp), .head_seq(sq_flat), .advance(advance),
        .sel_valid(sel_valid), .sel_tid(sel_tid)
    );

    commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u1 (
        .clk(clk), .rst_n(rst_n), .policy(pol1), .thr_state(st1),
        .head_ready(rdy1), .rob_empty(emp1), .head_seq(16'd9), .advance(1'b0),
        .sel_valid(s1_valid), .sel_tid(s1_tid)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected grant encoded as valid*8 + tid.
    task automatic expect_grant(input string req, input int v, input int t);
        #5;
        chk(req, int'(sel_valid) * 8 + int'(sel_tid), v * 8 + t);
    endtask

    task automatic set_all(input logic [2:0] s, input logic r, input logic e);
        for (int i = 0; i < N; i++) begin
            st[i] = s; rdy[i] = r; emp[i] = e; sq[i] = SW'(100 + i);
        end
    endtask

    task automatic pulse_adv;
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_order;
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd1;
        do_reset();
        expect_grant("R8 reset list front", 1, 0);
    endtask

    task automatic t_eligibility;
        @(negedge clk);
        set_all(3'd2, 1'b1, 1'b0);
        policy = 2'd2;
        sq[0] = 16'd1; sq[1] = 16'd2; sq[2] = 16'd3; sq[3] = 16'd4;
        st[0] = 3'd3; st[1] = 3'd5; st[2] = 3'd4;
        expect_grant("R1 fetch-trap wait eligible, trap/squash/5 not", 1, 2);
        st[2] = 3'd7;
        expect_grant("R1 all ineligible", 0, 0);
        st[3] = 3'd1;
        expect_grant("R1 idle eligible", 1, 3);
    endtask

    task automatic t_oldest;
        @(negedge clk);
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd2;
        sq[0] = 16'd50; sq[1] = 16'd20; sq[2] = 16'd30; sq[3] = 16'd40;
        expect_grant("R3 smallest sequence", 1, 1);
        rdy[1] = 1'b0;
        expect_grant("R3 not-ready excluded", 1, 2);
        emp[2] = 1'b1;
        expect_grant("R3 empty excluded", 1, 3);
        sq[0] = 16'hFFF0; sq[3] = 16'hFFFF;
        expect_grant("R3 unsigned compare", 1, 0);
    endtask

    task automatic t_tie;
        @(negedge clk);
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd2;
        sq[0] = 16'd90; sq[1] = 16'd80; sq[2] = 16'd7; sq[3] = 16'd7;
        expect_grant("R4 tie to lower index", 1, 2);
        policy = 2'd0;
        expect_grant("R4 tie greedy", 1, 2);
    endtask

    task automatic t_greedy;
        do_reset();
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd0;
        sq[0] = 16'd9; sq[1] = 16'd8; sq[2] = 16'd3; sq[3] = 16'd5;
        expect_grant("R5 greedy matches age", 1, 2);
        pulse_adv();
        expect_grant("R5 greedy repeat after advance", 1, 2);
        pulse_adv();
        policy = 2'd1;
        expect_grant("R7 advance under greedy left list intact", 1, 0);
    endtask

    task automatic t_rotate;
        do_reset();
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd1;
        for (int k = 0; k < 5; k++) begin
            expect_grant("R7 rotation order", 1, k % N);
            pulse_adv();
        end
        // list now 1,2,3,0
        rdy[1] = 1'b0;
        emp[2] = 1'b1;
        expect_grant("R6 skip not-ready, empty ignored", 1, 2);
        pulse_adv();
        // list now 1,3,0,2
        rdy[1] = 1'b1;
        expect_grant("R7 middle removal keeps order", 1, 1);
        rdy[1] = 1'b0;
        expect_grant("R7 next after removal", 1, 3);
        rdy[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_grant("R7 no advance holds list", 1, 1);
    endtask

    task automatic t_none;
        @(negedge clk);
        set_all(3'd0, 1'b0, 1'b0);
        policy = 2'd1;
        expect_grant("R9 none rotating", 0, 0);
        set_all(3'd0, 1'b1, 1'b1);
        policy = 2'd2;
        expect_grant("R9 none age all empty", 0, 0);
        set_all(3'd0, 1'b1, 1'b0);
        policy = 2'd3;
        expect_grant("R2 reserved policy", 0, 0);
    endtask

    task automatic t_single;
        @(negedge clk);
        st1 = 3'd0; rdy1 = 1'b0; emp1 = 1'b1; pol1 = 2'd3;
        #5 chk("R10 single running", int'(s1_valid) * 2 + int'(s1_tid), 2);
        st1 = 3'd2;
        #5 chk("R10 single squashing", int'(s1_valid), 0);
        st1 = 3'd4; pol1 = 2'd1;
        #5 chk("R10 single fetch-trap wait", int'(s1_valid) * 2 + int'(s1_tid), 2);
    endtask

    initial begin
        set_all(3'd0, 1'b0, 1'b0);
        t_reset_order();
        t_eligibility();
        t_oldest();
        t_tie();
        t_greedy();
        t_rotate();
        t_none();
        t_single();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            tests_run++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", tests_run, failed);
        $finish;
    end
endmodule